// File: doc/BRIEF.md
# Selectable Timing Divider Chain

This block turns one of two slow decade taps into a ladder of timing waveforms for a measurement sequencer. A complementary pair of select inputs names the range. `sel_hi` high with `sel_lo` low picks the coarse tap, which is the divide-by-100,000 output of the data counter. `sel_hi` low with `sel_lo` high picks the fine tap, which is the divide-by-10,000 output. Either tap is asymmetric. It stays high for nine tenths of its period and low for the last tenth: 9,000 and 1,000 counts in the fine range, 90,000 and 10,000 in the coarse range.

A small range state machine resamples the selected tap in the system clock domain. It has three states:
- `RNG_IDLE`: no valid range is held.
- `RNG_FINE`: the fine tap is followed.
- `RNG_COARSE`: the coarse tap is followed.

It has six named transitions:
- `IDLE->FINE`: a fine code while idle.
- `IDLE->COARSE`: a coarse code while idle.
- `FINE->COARSE`: a coarse code, taken only at a falling edge of the tap being followed.
- `COARSE->FINE`: a fine code, taken only at a falling edge of the tap being followed.
- `FINE->IDLE`: an invalid code.
- `COARSE->IDLE`: an invalid code.

Every detected falling edge of the resampled tap toggles a divide-by-two flip-flop. Every falling edge of that flip-flop advances a 4-bit binary counter. The resampled tap and the five divided square waves make six timing signals. The sequencer uses them to time run-up, the overload point, the sample-rate delay and the function delay.

Top module: `timing_ladder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `tick_base` at 0, `tick_div` at 0 and the range machine in `RNG_IDLE` after that edge.
- R2: With the range held in `RNG_COARSE` (code `sel_hi`=1, `sel_lo`=0), `tick_base` equals the value `tap_coarse` had at the previous clock edge, and `tap_fine` has no effect.
- R3: With the range held in `RNG_FINE` (code `sel_hi`=0, `sel_lo`=1), `tick_base` equals the value `tap_fine` had at the previous clock edge, and `tap_coarse` has no effect.
- R4: An invalid code (`sel_hi` equal to `sel_lo`) at a clock edge drives `tick_base` to 0 after that edge, leaves `tick_div` unchanged and moves the machine to `RNG_IDLE`.
- R5: `tick_div[0]` toggles in exactly the cycle in which `tick_base` falls from 1 to 0 under a valid code.
- R6: `tick_div[4:1]` is a binary count that increments by one, modulo 16, exactly when `tick_div[0]` falls from 1 to 0. The whole `tick_div` therefore wraps to 0 after 32 counted falling edges.
- R7: When a valid code names the other range, the machine keeps following the current tap and switches only at the clock edge where that tap's falling edge is detected. That falling edge is counted once, and the switch adds no extra falling edge.
- R8: From `RNG_IDLE`, a valid code moves the machine to its range at the next edge. `tick_base` stays 0 at that edge and follows the new tap from the edge after.
- R9: `tick_div` changes only at an edge where `tick_base` falls. Rising edges and steady levels of the tap leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_hi | input | 1 | Range select, high half of the complementary pair |
| sel_lo | input | 1 | Range select, low half of the complementary pair |
| tap_coarse | input | 1 | Divide-by-100,000 decade tap, 90% duty |
| tap_fine | input | 1 | Divide-by-10,000 decade tap, 90% duty |
| tick_base | output | 1 | Resampled selected tap, the first timing signal |
| tick_div | output | CNT_W+1 | Bit 0 is the toggle flip-flop; bits 4:1 are the binary counter |

## Verification
All state except the range machine is visible directly on the ports. A wrong divider or counter bit therefore shows in `tick_div` in the very cycle it goes wrong. A range machine stuck in the wrong state shows within one clock. It shows as `tick_base` following the unselected tap, staying low under a valid code, or staying high under an invalid one. A switch taken at the wrong time shows as an extra or missing falling edge, which the 5-bit count keeps visible for the rest of the run.

// File: rtl/timing_ladder_pkg.sv
package timing_ladder_pkg;

    typedef enum logic [1:0] {
        RNG_IDLE   = 2'd0,
        RNG_FINE   = 2'd1,
        RNG_COARSE = 2'd2
    } rng_e;

    // Complementary pair: 10 -> coarse, 01 -> fine, equal -> invalid.
    function automatic rng_e decode_sel(input logic hi, input logic lo);
        if (hi && !lo)      return RNG_COARSE;
        else if (!hi && lo) return RNG_FINE;
        else                return RNG_IDLE;
    endfunction

endpackage

// File: rtl/tl_range_fsm.sv
module tl_range_fsm
    import timing_ladder_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel_hi,
    input  logic sel_lo,
    input  logic tap_coarse,
    input  logic tap_fine,
    output logic tap_q,
    output logic fall_stb
);

    rng_e state_q;
    rng_e state_d;
    rng_e req;
    logic tap_now;

    assign req = decode_sel(sel_hi, sel_lo);

    // Output process: tap routed by the held range.
    always_comb begin
        unique case (state_q)
            RNG_FINE:   tap_now = tap_fine;
            RNG_COARSE: tap_now = tap_coarse;
            default:    tap_now = 1'b0;
        endcase
    end

    // A falling edge counts only while the request is valid.
    assign fall_stb = tap_q & ~tap_now & (req != RNG_IDLE);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RNG_IDLE: state_d = req;
            RNG_FINE: begin
                if (req == RNG_IDLE)
                    state_d = RNG_IDLE;
                else if (req == RNG_COARSE && fall_stb)
                    state_d = RNG_COARSE;
            end
            RNG_COARSE: begin
                if (req == RNG_IDLE)
                    state_d = RNG_IDLE;
                else if (req == RNG_FINE && fall_stb)
                    state_d = RNG_FINE;
            end
            default: state_d = RNG_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= RNG_IDLE;
        else     state_q <= state_d;
    end

    // Tap resampler, forced low under an invalid request.
    always_ff @(posedge clk) begin
        if (rst)                  tap_q <= 1'b0;
        else if (req == RNG_IDLE) tap_q <= 1'b0;
        else                      tap_q <= tap_now;
    end

endmodule

// File: rtl/tl_div_chain.sv
module tl_div_chain #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [CNT_W:0]   taps
);

    logic             half_q;
    logic [CNT_W-1:0] cnt_q;

    // Divide-by-two stage.
    always_ff @(posedge clk) begin
        if (rst)       half_q <= 1'b0;
        else if (step) half_q <= ~half_q;
    end

    // Binary counter advanced on the falling edge of the toggle stage.
    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (step && half_q) cnt_q <= cnt_q + 1'b1;
    end

    assign taps[0] = half_q;
    for (genvar i = 0; i < CNT_W; i++) begin : g_pack
        assign taps[i+1] = cnt_q[i];
    end

endmodule

// File: rtl/timing_ladder.sv
module timing_ladder #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_hi,
    input  logic             sel_lo,
    input  logic             tap_coarse,
    input  logic             tap_fine,
    output logic             tick_base,
    output logic [CNT_W:0]   tick_div
);

    localparam int DIV_W = CNT_W + 1;

    logic             fall_stb;
    logic [DIV_W-1:0] div_taps;

    tl_range_fsm u_range (
        .clk        (clk),
        .rst        (rst),
        .sel_hi     (sel_hi),
        .sel_lo     (sel_lo),
        .tap_coarse (tap_coarse),
        .tap_fine   (tap_fine),
        .tap_q      (tick_base),
        .fall_stb   (fall_stb)
    );

    tl_div_chain #(.CNT_W(CNT_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .step (fall_stb),
        .taps (div_taps)
    );

    assign tick_div = div_taps;

endmodule

// File: rtl/timing_ladder_chk.sv
module timing_ladder_chk #(
    parameter int DIV_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             sel_hi,
    input logic             sel_lo,
    input logic             tick_base,
    input logic [DIV_W-1:0] tick_div
);

    localparam int UW = DIV_W - 1;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (tick_div == '0 && !tick_base)); // R1

    AST_INVALID_LOW: assert property (@(posedge clk) disable iff (rst)
        (sel_hi == sel_lo) |=> !tick_base); // R4

    AST_INVALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sel_hi == sel_lo) |=> $stable(tick_div)); // R4

    AST_HALF_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        ($fell(tick_base) && $past(sel_hi != sel_lo) && !$past(rst))
        |-> (tick_div[0] != $past(tick_div[0]))); // R5

    AST_UPPER_STEP: assert property (@(posedge clk) disable iff (rst)
        ($fell(tick_div[0]) && !$past(rst))
        |-> ((tick_div[DIV_W-1:1] - $past(tick_div[DIV_W-1:1])) == UW'(1))); // R6

    AST_QUIET_NO_FALL: assert property (@(posedge clk) disable iff (rst)
        (!$fell(tick_base) && !$past(rst)) |-> $stable(tick_div)); // R9

endmodule

bind timing_ladder timing_ladder_chk #(.DIV_W(CNT_W + 1)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel_hi    (sel_hi),
    .sel_lo    (sel_lo),
    .tick_base (tick_base),
    .tick_div  (tick_div)
);

// File: tb/timing_ladder_tb_top.sv
module timing_ladder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    // Vector: {sel_hi, sel_lo, tap_coarse, tap_fine, exp_base, exp_div[4:0]}
    localparam logic [9:0] VEC [NVEC] = '{
        {4'b0111, 1'b0, 5'd0},  // idle -> fine (R8)
        {4'b0101, 1'b1, 5'd0},  // follows fine (R3)
        {4'b0100, 1'b0, 5'd1},  // fall (R5)
        {4'b0111, 1'b1, 5'd1},
        {4'b0100, 1'b0, 5'd2},  // fall, half falls (R6)
        {4'b0101, 1'b1, 5'd2},
        {4'b1011, 1'b1, 5'd2},  // coarse asked, no fall yet (R7)
        {4'b1010, 1'b0, 5'd3},  // fall -> switch (R7)
        {4'b1010, 1'b1, 5'd3},  // follows coarse (R2)
        {4'b1001, 1'b0, 5'd4},
        {4'b1010, 1'b1, 5'd4},
        {4'b1100, 1'b0, 5'd4},  // invalid: low, hold (R4)
        {4'b0011, 1'b0, 5'd4},
        {4'b1001, 1'b0, 5'd4},  // idle -> coarse (R8)
        {4'b1010, 1'b1, 5'd4},
        {4'b1000, 1'b0, 5'd5}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_hi = 1'b0;
    logic       sel_lo = 1'b0;
    logic       tap_coarse = 1'b0;
    logic       tap_fine = 1'b0;
    logic       tick_base;
    logic [4:0] tick_div;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timing_ladder #(.CNT_W(4)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .sel_hi     (sel_hi),
        .sel_lo     (sel_lo),
        .tap_coarse (tap_coarse),
        .tap_fine   (tap_fine),
        .tick_base  (tick_base),
        .tick_div   (tick_div)
    );

    task automatic drive(input logic r, input logic sh, input logic sl,
                         input logic tc, input logic tf);
        rst = r; sel_hi = sh; sel_lo = sl; tap_coarse = tc; tap_fine = tf;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [5:0] act,
                         input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin
        int falls;
        @(negedge clk);
        for (int k = 0; k < 4; k++) drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R1 reset state", {tick_base, tick_div}, 6'd0);

        for (int i = 0; i < NVEC; i++) begin
            drive(1'b0, VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6]);
            check($sformatf("R2 R3 R4 R5 R7 R8 R9 table row %0d", i),
                  {tick_base, tick_div}, VEC[i][5:0]);
        end

        // Long fine-range run, 9 high / 1 low, coarse tap in antiphase.
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R1 reset after table", {tick_base, tick_div}, 6'd0);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R8 idle to fine", {tick_base, tick_div}, 6'd0);
        falls = 0;
        for (int p = 0; p < 34; p++) begin
            for (int h = 0; h < 9; h++) begin
                drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
                check("R3 R9 fine high phase", {tick_base, tick_div},
                      {1'b1, 5'(falls)});
            end
            drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
            falls++;
            // After 32 falls the whole ladder wraps to zero (R6).
            check("R5 R6 fine falling edge", {tick_base, tick_div},
                  {1'b0, 5'(falls % 32)});
        end

        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R3 before mid-run reset", {tick_base, tick_div}, {1'b1, 5'd2});
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R1 mid-run reset", {tick_base, tick_div}, 6'd0);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        check("R4 invalid after reset", {tick_base, tick_div}, 6'd0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule